// File: doc/BRIEF.md
# LMS Tap Weight Updater with Serial Product and Shift-Based Error Scaling

This block keeps one coefficient of an adaptive FIR filter and applies the least-mean-square correction to it once per sample: the new weight is the old weight plus the step size times the error times the delayed input sample that belongs to this tap. It has no general multiplier. The product of step size and sample is built bit-serially, one sample bit per clock, with a single-term distributed-arithmetic accumulator. This runs alongside the filter's own bit-serial pass. The error arrives already quantized to a signed power of two, so scaling by it is a one-cycle barrel shift followed by an optional negation. A saturating adder then writes the weight register.

A request is a one-cycle start strobe that carries the tap sample, the step size, and the quantized error. The error is given as a sign flag and a right-shift count. The block reports busy while the request is in flight, and it pulses a done flag in the same cycle that the updated weight first shows on the output. One updater is placed per tap. Error generation and the filter datapath lie outside the block.

Top module: `lmsu_weight_update`

## Requirements
- R1: While reset is held, and after it is released, the weight output is 0 and both done and busy are 0 until the first accepted start.
- R2: An accepted update with error sign flag 0 and shift count k adds floor((mu * x) / 2^k) to the weight. Here x is the signed sample and mu is the unsigned step size.
- R3: With the error sign flag at 1, the same shifted product is subtracted from the weight (two's complement negation before the add).
- R4: A sum above the largest signed weight value leaves the weight at that maximum (32767 with default widths) instead of wrapping.
- R5: A sum below the smallest signed weight value leaves the weight at that minimum (-32768 with default widths) instead of wrapping.
- R6: Done is high for exactly one cycle. It rises SAMPLE_W+2 clock edges after the edge that samples the start strobe, and the new weight appears in that same cycle.
- R7: Busy is high from the cycle after an accepted start until done rises. A start strobe seen while busy is high is ignored and changes neither the weight nor the number of done pulses.
- R8: The sample is two's complement, and its most significant bit carries negative weight: x = -128 with mu = 255 gives a product of -32640.
- R9: The shift count covers the whole range 0 to 2^SHIFT_W-1, and the right shift is arithmetic: a product of -1 shifted by 7 contributes -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an update when busy is low |
| x_i | input | SAMPLE_W | Signed tap sample x[n-i] |
| mu_i | input | MU_W | Unsigned step size |
| err_neg_i | input | 1 | Quantized error sign, 1 = negative |
| err_shift_i | input | SHIFT_W | Error magnitude exponent k, error = ±2^-k |
| weight_o | output | WEIGHT_W | Current signed weight |
| done_o | output | 1 | One-cycle pulse when a new weight is written |
| busy_o | output | 1 | An update is in progress |

## Verification
The bench uses the default widths: an 8-bit sample, an 8-bit step size, a 16-bit weight and a 3-bit shift count. With these values the largest product, 32640, is just below the weight's positive limit. Two same-sign updates therefore push the weight into either saturation bound, and a single update from a large opposite-signed weight crosses zero. The 3-bit shift count lets the bench reach the maximum shift of 7, where flooring of small negative products shows up. The most negative sample, -128, exercises the subtracted sign-bit term of the serial multiplier.

// File: rtl/lmsu_pkg.sv
package lmsu_pkg;

  // Limit a value to the signed range of a w-bit two's complement word.
  function automatic longint lmsu_clamp(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // One distributed-arithmetic step: weight mu by bit p of the sample;
  // the sign bit contributes negatively.
  function automatic longint lmsu_da_term(longint mu, logic bit_v, logic is_msb, int p);
    longint t;
    t = bit_v ? (mu <<< p) : longint'(0);
    return is_msb ? -t : t;
  endfunction

  // Multiply by a signed power-of-two error: arithmetic right shift, then
  // optional negation.
  function automatic longint lmsu_pow2_scale(longint prod, int k, logic neg);
    longint s;
    s = prod >>> k;
    return neg ? -s : s;
  endfunction

endpackage

// File: rtl/lmsu_da_mult.sv
module lmsu_da_mult #(
  parameter int SAMPLE_W = 8,
  parameter int MU_W     = 8,
  parameter int PROD_W   = SAMPLE_W + MU_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [SAMPLE_W-1:0]      x_i,
  input  logic [MU_W-1:0]          mu_i,
  output logic                     busy_o,
  output logic signed [PROD_W-1:0] prod_o,
  output logic                     prod_valid_o
);
  import lmsu_pkg::*;

  localparam int CNT_W = (SAMPLE_W > 2) ? $clog2(SAMPLE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0]      x_sr;
  logic [MU_W-1:0]          mu_q;
  logic signed [PROD_W-1:0] acc;
  logic [CNT_W-1:0]         cnt;
  logic                     run;
  logic                     pv;

  logic                     at_msb;
  logic signed [PROD_W-1:0] acc_next;

  always_comb begin
    at_msb   = (cnt == LAST);
    acc_next = PROD_W'(longint'(acc)
             + lmsu_da_term(longint'(mu_q), x_sr[0], at_msb, int'(cnt)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_sr <= '0;
      mu_q <= '0;
      acc  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      pv   <= 1'b0;
    end else if (load_i) begin
      x_sr <= x_i;
      mu_q <= mu_i;
      acc  <= '0;
      cnt  <= '0;
      run  <= 1'b1;
      pv   <= 1'b0;
    end else if (run) begin
      acc  <= acc_next;
      x_sr <= {1'b0, x_sr[SAMPLE_W-1:1]};
      cnt  <= cnt + CNT_W'(1);
      if (at_msb) begin
        run <= 1'b0;
        pv  <= 1'b1;
      end
    end else begin
      pv <= 1'b0;
    end
  end

  assign busy_o       = run;
  assign prod_o       = acc;
  assign prod_valid_o = pv;
endmodule

// File: rtl/lmsu_pow2_shift.sv
module lmsu_pow2_shift #(
  parameter int PROD_W  = 17,
  parameter int SHIFT_W = 3,
  parameter int CORR_W  = PROD_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prod_valid_i,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic                     neg_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  output logic signed [CORR_W-1:0] corr_o,
  output logic                     corr_valid_o
);
  import lmsu_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_o       <= '0;
      corr_valid_o <= 1'b0;
    end else begin
      corr_valid_o <= prod_valid_i;
      if (prod_valid_i)
        corr_o <= CORR_W'(lmsu_pow2_scale(longint'(prod_i), int'(shift_i), neg_i));
    end
  end
endmodule

// File: rtl/lmsu_sat_acc.sv
module lmsu_sat_acc #(
  parameter int CORR_W   = 18,
  parameter int WEIGHT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       corr_valid_i,
  input  logic signed [CORR_W-1:0]   corr_i,
  output logic signed [WEIGHT_W-1:0] weight_o,
  output logic                       done_o
);
  import lmsu_pkg::*;

  logic signed [WEIGHT_W-1:0] w_next;

  always_comb begin
    w_next = WEIGHT_W'(lmsu_clamp(longint'(weight_o) + longint'(corr_i), WEIGHT_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weight_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= corr_valid_i;
      if (corr_valid_i) weight_o <= w_next;
    end
  end
endmodule

// File: rtl/lmsu_weight_update.sv
module lmsu_weight_update #(
  parameter int SAMPLE_W = 8,
  parameter int MU_W     = 8,
  parameter int WEIGHT_W = 16,
  parameter int SHIFT_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SAMPLE_W-1:0] x_i,
  input  logic [MU_W-1:0]     mu_i,
  input  logic                err_neg_i,
  input  logic [SHIFT_W-1:0]  err_shift_i,
  output logic [WEIGHT_W-1:0] weight_o,
  output logic                done_o,
  output logic                busy_o
);
  localparam int PROD_W = SAMPLE_W + MU_W + 1;
  localparam int CORR_W = PROD_W + 1;

  // Named internal events, brought out for the bound checker.
  logic                     accept;
  logic                     mult_busy;
  logic                     prod_valid;
  logic                     corr_valid;
  logic                     corr_neg;
  logic signed [PROD_W-1:0] prod;
  logic signed [CORR_W-1:0] corr;
  logic signed [WEIGHT_W-1:0] weight_s;

  logic                     neg_q;
  logic [SHIFT_W-1:0]       shift_q;

  assign busy_o   = mult_busy | prod_valid | corr_valid;
  assign accept   = start_i & ~busy_o;
  assign corr_neg = corr[CORR_W-1];
  assign weight_o = weight_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q   <= 1'b0;
      shift_q <= '0;
    end else if (accept) begin
      neg_q   <= err_neg_i;
      shift_q <= err_shift_i;
    end
  end

  lmsu_da_mult #(
    .SAMPLE_W(SAMPLE_W), .MU_W(MU_W), .PROD_W(PROD_W)
  ) u_mult (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .x_i(x_i), .mu_i(mu_i),
    .busy_o(mult_busy), .prod_o(prod), .prod_valid_o(prod_valid)
  );

  lmsu_pow2_shift #(
    .PROD_W(PROD_W), .SHIFT_W(SHIFT_W), .CORR_W(CORR_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .prod_valid_i(prod_valid), .prod_i(prod),
    .neg_i(neg_q), .shift_i(shift_q), .corr_o(corr), .corr_valid_o(corr_valid)
  );

  lmsu_sat_acc #(
    .CORR_W(CORR_W), .WEIGHT_W(WEIGHT_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .corr_valid_i(corr_valid), .corr_i(corr),
    .weight_o(weight_s), .done_o(done_o)
  );
endmodule

// File: rtl/lmsu_checker.sv
module lmsu_checker #(
  parameter int WEIGHT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [WEIGHT_W-1:0] weight_o,
  input logic                prod_valid,
  input logic                corr_valid,
  input logic                corr_neg
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_after_corr: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(corr_valid));

  a_r6_corr_after_prod: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> $past(prod_valid));

  a_r7_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r2_weight_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(weight_o) |-> done_o);

  a_r4_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(corr_neg)) |-> ($signed(weight_o) >= $signed($past(weight_o))));

  a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(corr_neg)) |-> ($signed(weight_o) <= $signed($past(weight_o))));
endmodule

bind lmsu_weight_update lmsu_checker #(.WEIGHT_W(WEIGHT_W)) u_lmsu_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .weight_o(weight_o), .prod_valid(prod_valid), .corr_valid(corr_valid),
  .corr_neg(corr_neg)
);

// File: tb/test_lmsu_weight_update.sv
module test_lmsu_weight_update;
  localparam int SW = 8;
  localparam int MW = 8;
  localparam int WW = 16;
  localparam int HW = 3;
  localparam int LAT = SW + 3; // negedge cycles from drive to done

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] x = '0;
  logic [MW-1:0] mu = '0;
  logic          eneg = 1'b0;
  logic [HW-1:0] esh = '0;
  logic [WW-1:0] w;
  logic          done;
  logic          busy;

  lmsu_weight_update #(.SAMPLE_W(SW), .MU_W(MW), .WEIGHT_W(WW), .SHIFT_W(HW)) i_lmsu_weight_update (
    .clk(clk), .rst_n(rst_n), .start_i(start), .x_i(x), .mu_i(mu),
    .err_neg_i(eneg), .err_shift_i(esh), .weight_o(w), .done_o(done), .busy_o(busy)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    w;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   model_w = 0;
  bit   finished = 0;
  bit   prev_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: pop and compare on each done pulse.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done && prev_done) check(0, "R6 done longer than one cycle", 1, 0);
      if (done) begin
        if (q.size() == 0) begin
          check(0, "R7 unexpected done pulse", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check($signed(w) == e.w, e.tag, int'($signed(w)), e.w);
          check(cyc == e.cyc, "R6 done latency", cyc, e.cyc);
        end
      end
      prev_done = done;
    end
  end

  function automatic int ref_update(int wcur, int xs, int m, bit n, int k);
    int p;
    int c;
    int s;
    p = xs * m;
    c = p >>> k;
    if (n) c = -c;
    s = wcur + c;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  // Driver: issue one update and push the expected result.
  task automatic issue(int xs, int m, bit n, int k, string tag, bit glitch);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    x = SW'(xs); mu = MW'(m); eneg = n; esh = HW'(k); start = 1'b1;
    model_w = ref_update(model_w, xs, m, n, k);
    e.w = model_w; e.cyc = cyc + LAT; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    if (glitch) begin
      repeat (2) @(negedge clk);
      x = SW'(127); mu = MW'(255); eneg = 1'b0; esh = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(w == '0 && done == 0 && busy == 0, "R1 state in reset", int'(w), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check($signed(w) == 0, "R1 weight after reset", int'($signed(w)), 0);
    check(done == 0, "R1 done after reset", int'(done), 0);
    check(busy == 0, "R1 busy after reset", int'(busy), 0);

    issue(10, 16, 0, 0, "R2 plain add", 0);
    issue(-7, 100, 0, 2, "R2 shifted negative product", 0);
    issue(-128, 255, 1, 0, "R3 R8 negated min sample", 0);
    issue(127, 255, 0, 0, "R4 saturate high", 0);
    issue(127, 255, 0, 0, "R4 hold at max", 0);
    issue(127, 255, 1, 0, "R3 negative error", 0);
    issue(-128, 255, 0, 0, "R8 sign bit weight", 0);
    issue(-128, 255, 0, 0, "R5 saturate low", 0);
    issue(0, 255, 0, 0, "R2 zero sample", 0);
    issue(100, 200, 0, 7, "R9 max shift", 0);
    issue(-1, 1, 0, 7, "R9 arithmetic shift floor", 0);
    issue(50, 3, 1, 1, "R7 start ignored while busy", 1);
    issue(5, 5, 0, 0, "R2 after ignored start", 0);

    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R7 no pending results", q.size(), 0);
    check($signed(w) == model_w, "R7 final weight", int'($signed(w)), model_w);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule